// File: doc/BRIEF.md
# Raster Line and Light-Pen Interrupt Controller

This block sits next to a video timing generator and turns two raster events into CPU interrupts. Software writes three ports: a vector byte, a control byte with an enable bit and a mode bit for each source, and a target scan line. A line interrupt is requested when the vertical counter equals the target line at the start of that line. A pen interrupt is requested when the light-pen strobe fires. On a pen event the block captures the vertical and horizontal raster position, and software reads them back through the control and target-line port addresses.

The request output is active-low and stays low while either source is pending. During an acknowledge cycle the block drives the stored vector byte onto a separate vector bus and retires one source. The pen source has priority over the line source. In clear-on-acknowledge mode the served source is retired. In hold mode it stays pending until software writes the control port again.

Top module: `rastirq_unit`

## Requirements
- R1: After reset `irq_n` is 1, `vec_oe` is 0, `vec_out` is 0, both sources are disabled, and reads of 0x0E and 0x0F return 0.
- R2: A write to address 0x0D stores the vector byte. While `iack` is 1, `vec_oe` is 1 and `vec_out` carries that byte. Otherwise `vec_oe` is 0 and `vec_out` is 0.
- R3: With control bit 3 set, a cycle with `line_start`=1 and `vcount` equal to the value written to 0x0F makes `irq_n` 0 from the next clock edge. `vcount` matching without `line_start` raises nothing.
- R4: With control bit 1 set, a cycle with `pen_strobe`=1 makes `irq_n` 0 from the next clock edge.
- R5: While `rd_en` is 1, `rdata` shows the captured vertical position at address 0x0E and the captured horizontal position at 0x0F. Any other address reads 0.
- R6: An accepted pen strobe captures `vcount` and `hcount` only when no pen interrupt is pending. While one is pending, the captured values do not change.
- R7: When both sources are pending, an acknowledge retires the pen source first. The line source stays pending and `irq_n` stays 0 until a second acknowledge.
- R8: Control bit 2 (line) and bit 0 (pen) select the mode. A mode value of 0 retires the served source on acknowledge. A mode value of 1 keeps it pending through any number of acknowledges.
- R9: Any write to address 0x0E retires both pending sources. An event in the write cycle is judged against the previous enables.
- R10: A new accepted event that coincides with the acknowledge that retires the same source leaves that source pending.
- R11: When a source's enable bit is 0, its events raise nothing, and a disabled pen strobe leaves the captured position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (position capture) |
| line_start | input | 1 | Pulse at the start of each scan line |
| vcount | input | 8 | Current vertical raster line |
| hcount | input | 8 | Current horizontal raster position |
| pen_strobe | input | 1 | Light-pen hit pulse |
| iack | input | 1 | Interrupt acknowledge cycle |
| irq_n | output | 1 | Active-low interrupt request |
| vec_oe | output | 1 | Vector bus drive enable |
| vec_out | output | 8 | Vector byte during acknowledge |

## Verification
Two pairs of functions can fall in the same clock cycle. An acknowledge can meet a fresh pen strobe, and a line hit can meet a pen strobe. The bench drives `iack` together with a new strobe whose position differs from the one already captured. It expects the request to stay low and the readback to keep the earlier position. It then fires a line hit and a pen strobe in one cycle, with both sources enabled. It expects the first acknowledge to leave the request low and the second to release it.

// File: rtl/rastirq_pkg.sv
package rastirq_pkg;
    // Control byte, low nibble: bit 3 line enable, bit 2 line mode,
    // bit 1 pen enable, bit 0 pen mode.
    typedef struct packed {
        logic line_en;
        logic line_hold;
        logic pen_en;
        logic pen_hold;
    } irq_ctrl_t;

    localparam int CTRL_W = $bits(irq_ctrl_t);
endpackage

// File: rtl/rastirq_regs.sv
module rastirq_regs
    import rastirq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int VPOS_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_VEC  = 'h0D,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h0E,
    parameter logic [ADDR_W-1:0] ADDR_LINE = 'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] vec_o,
    output logic [VPOS_W-1:0] line_o,
    output irq_ctrl_t         ctrl_o,
    output logic              ctrl_wr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] vec;
        logic [VPOS_W-1:0] line;
        irq_ctrl_t         ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == ADDR_VEC)  r_d.vec  = wdata;
            if (addr == ADDR_LINE) r_d.line = wdata[VPOS_W-1:0];
            if (addr == ADDR_CTRL) r_d.ctrl = irq_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vec_o     = r_q.vec;
    assign line_o    = r_q.line;
    assign ctrl_o    = r_q.ctrl;
    assign ctrl_wr_o = wr_en && (addr == ADDR_CTRL);
endmodule

// File: rtl/rastirq_arb.sv
module rastirq_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hit,
    input  logic pen_hit,
    input  logic iack,
    input  logic ctrl_wr,
    input  logic line_hold,
    input  logic pen_hold,
    output logic line_pend_o,
    output logic pen_pend_o
);
    typedef struct packed {
        logic line_pend;
        logic pen_pend;
    } arb_t;

    arb_t a_d, a_q;
    logic serve_pen, serve_line;

    always_comb begin
        serve_pen  = iack && a_q.pen_pend;
        serve_line = iack && a_q.line_pend && !a_q.pen_pend;
        a_d = a_q;
        if (ctrl_wr) begin
            a_d.pen_pend  = 1'b0;
            a_d.line_pend = 1'b0;
        end else begin
            if (serve_pen && !pen_hold)   a_d.pen_pend  = 1'b0;
            if (serve_line && !line_hold) a_d.line_pend = 1'b0;
        end
        if (pen_hit)  a_d.pen_pend  = 1'b1;
        if (line_hit) a_d.line_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign line_pend_o = a_q.line_pend;
    assign pen_pend_o  = a_q.pen_pend;

    // R7
    pen_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && pen_pend_o && line_pend_o && !ctrl_wr) |=> line_pend_o);

    // R8
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && pen_pend_o && !pen_hold && !pen_hit) |=> !pen_pend_o);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && pen_pend_o && pen_hold && !ctrl_wr) |=> pen_pend_o);
endmodule

// File: rtl/rastirq_penlat.sv
module rastirq_penlat #(
    parameter int VPOS_W = 8,
    parameter int HPOS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pen_hit,
    input  logic              pen_pend,
    input  logic [VPOS_W-1:0] vcount,
    input  logic [HPOS_W-1:0] hcount,
    output logic [VPOS_W-1:0] vpos_o,
    output logic [HPOS_W-1:0] hpos_o
);
    typedef struct packed {
        logic [VPOS_W-1:0] v;
        logic [HPOS_W-1:0] h;
    } pos_t;

    pos_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (pen_hit && !pen_pend) begin
            p_d.v = vcount;
            p_d.h = hcount;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign vpos_o = p_q.v;
    assign hpos_o = p_q.h;

    // R6
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pen_pend |=> ($stable(vpos_o) && $stable(hpos_o)));

    // R6
    pos_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_hit && !pen_pend) |=> (vpos_o == $past(vcount)));
endmodule

// File: rtl/rastirq_unit.sv
module rastirq_unit
    import rastirq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int VPOS_W = 8,
    parameter int HPOS_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_VEC  = 'h0D,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h0E,
    parameter logic [ADDR_W-1:0] ADDR_LINE = 'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              line_start,
    input  logic [VPOS_W-1:0] vcount,
    input  logic [HPOS_W-1:0] hcount,
    input  logic              pen_strobe,
    input  logic              iack,
    output logic              irq_n,
    output logic              vec_oe,
    output logic [DATA_W-1:0] vec_out
);
    logic [DATA_W-1:0] vec_q;
    logic [VPOS_W-1:0] line_q;
    irq_ctrl_t         ctrl_q;
    logic              ctrl_wr;
    logic              line_hit, pen_hit;
    logic              line_pend, pen_pend;
    logic [VPOS_W-1:0] vpos_q;
    logic [HPOS_W-1:0] hpos_q;

    rastirq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VPOS_W(VPOS_W),
        .ADDR_VEC(ADDR_VEC), .ADDR_CTRL(ADDR_CTRL), .ADDR_LINE(ADDR_LINE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .vec_o(vec_q), .line_o(line_q), .ctrl_o(ctrl_q), .ctrl_wr_o(ctrl_wr)
    );

    always_comb begin
        line_hit = line_start && ctrl_q.line_en && (vcount == line_q);
        pen_hit  = pen_strobe && ctrl_q.pen_en;
    end

    rastirq_arb u_arb (
        .clk(clk), .rst_n(rst_n), .line_hit(line_hit), .pen_hit(pen_hit),
        .iack(iack), .ctrl_wr(ctrl_wr), .line_hold(ctrl_q.line_hold),
        .pen_hold(ctrl_q.pen_hold), .line_pend_o(line_pend), .pen_pend_o(pen_pend)
    );

    rastirq_penlat #(.VPOS_W(VPOS_W), .HPOS_W(HPOS_W)) u_penlat (
        .clk(clk), .rst_n(rst_n), .pen_hit(pen_hit), .pen_pend(pen_pend),
        .vcount(vcount), .hcount(hcount), .vpos_o(vpos_q), .hpos_o(hpos_q)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_CTRL)      rdata = DATA_W'(vpos_q);
            else if (addr == ADDR_LINE) rdata = DATA_W'(hpos_q);
        end
        irq_n   = !(line_pend || pen_pend);
        vec_oe  = iack;
        vec_out = iack ? vec_q : '0;
    end

    // R3
    line_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_hit |=> !irq_n);

    // R9
    ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !line_hit && !pen_hit) |=> irq_n);

    // R10
    ack_new_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && pen_hit) |=> !irq_n);
endmodule

// File: tb/rastirq_unit_tb.sv
`timescale 1ns/100ps
module rastirq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       line_start = 1'b0, pen_strobe = 1'b0, iack = 1'b0;
    logic [7:0] vcount = '0, hcount = '0;
    logic       irq_n, vec_oe;
    logic [7:0] vec_out;

    always #2.5 clk = ~clk;

    rastirq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .line_start(line_start), .vcount(vcount),
        .hcount(hcount), .pen_strobe(pen_strobe), .iack(iack), .irq_n(irq_n),
        .vec_oe(vec_oe), .vec_out(vec_out)
    );

    localparam int SIG_IRQ = 0, SIG_RD = 1, SIG_VEC = 2, SIG_OE = 3;

    typedef struct {
        int         at;
        int         sig;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sbq[$];
    int cyc = 0, checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic push(string req, int sig, logic [7:0] v);
        sb_item_t it;
        it.at = cyc + 1; it.sig = sig; it.exp = v; it.req = req;
        sbq.push_back(it);
    endtask

    // Monitor: sample 1 ns after each rising edge
    initial forever begin
        @(posedge clk);
        cyc++;
        #1;
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            sb_item_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            case (it.sig)
                SIG_IRQ: act = {7'b0, irq_n};
                SIG_RD:  act = rdata;
                SIG_VEC: act = vec_out;
                default: act = {7'b0, vec_oe};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sig=%0d cycle=%0d actual=%02h expected=%02h",
                         it.req, it.sig, cyc, act, it.exp);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 0; rd_en = 0; line_start = 0; pen_strobe = 0; iack = 0;
    endtask
    task automatic wr(logic [7:0] a, logic [7:0] d);
        idle(); wr_en = 1; addr = a; wdata = d;
    endtask
    task automatic rd(logic [7:0] a, string req, logic [7:0] e);
        idle(); rd_en = 1; addr = a; push(req, SIG_RD, e);
    endtask
    task automatic line_ev(logic [7:0] v);
        idle(); line_start = 1; vcount = v;
    endtask
    task automatic pen_ev(logic [7:0] v, logic [7:0] h);
        idle(); pen_strobe = 1; vcount = v; hcount = h;
    endtask
    task automatic ack();
        idle(); iack = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        idle(); push("R1", SIG_IRQ, 1); push("R1", SIG_OE, 0); push("R1", SIG_VEC, 0);
        rd(8'h0E, "R1", 8'h00);
        rd(8'h0F, "R1", 8'h00);
        // Program vector, target line, line enable (mode 0)
        wr(8'h0D, 8'hA5);
        wr(8'h0F, 8'd20);
        wr(8'h0E, 8'h08);
        // R3 line match only on target
        line_ev(8'd19); push("R3", SIG_IRQ, 1);
        line_ev(8'd20); push("R3", SIG_IRQ, 0);
        idle();         push("R3", SIG_IRQ, 0);
        // R2 vector during acknowledge, R8 mode 0 clears
        ack();  push("R2", SIG_OE, 1); push("R2", SIG_VEC, 8'hA5); push("R8", SIG_IRQ, 1);
        idle(); push("R2", SIG_OE, 0); push("R2", SIG_VEC, 8'h00);
        // R3 no request without line_start although vcount matches
        idle(); push("R3", SIG_IRQ, 1);
        // R4 pen interrupt and R5 readback
        wr(8'h0E, 8'h02);
        pen_ev(8'd33, 8'd91); push("R4", SIG_IRQ, 0);
        rd(8'h0E, "R5", 8'd33);
        rd(8'h0F, "R5", 8'd91);
        rd(8'h0D, "R5", 8'h00);
        // R6 capture frozen while pending
        pen_ev(8'd40, 8'd12);
        rd(8'h0E, "R6", 8'd33);
        rd(8'h0F, "R6", 8'd91);
        // R9 control write retires pending
        wr(8'h0E, 8'h0A); push("R9", SIG_IRQ, 1);
        // R7 both in one cycle, pen first
        idle(); line_start = 1; pen_strobe = 1; vcount = 8'd20; hcount = 8'd5;
        push("R7", SIG_IRQ, 0);
        rd(8'h0E, "R6", 8'd20);
        rd(8'h0F, "R6", 8'd5);
        ack(); push("R7", SIG_IRQ, 0);
        ack(); push("R7", SIG_IRQ, 1);
        // R8 hold mode
        wr(8'h0E, 8'h0C);
        line_ev(8'd20); push("R8", SIG_IRQ, 0);
        ack();          push("R8", SIG_IRQ, 0);
        ack();          push("R8", SIG_IRQ, 0);
        wr(8'h0E, 8'h0C); push("R9", SIG_IRQ, 1);
        // R10 acknowledge meets new pen strobe
        wr(8'h0E, 8'h02);
        pen_ev(8'd7, 8'd8); push("R10", SIG_IRQ, 0);
        idle(); iack = 1; pen_strobe = 1; vcount = 8'd9; hcount = 8'd10;
        push("R10", SIG_IRQ, 0);
        rd(8'h0E, "R10", 8'd7);
        ack(); push("R10", SIG_IRQ, 1);
        // R11 disabled sources
        wr(8'h0E, 8'h00);
        pen_ev(8'd50, 8'd77); push("R11", SIG_IRQ, 1);
        line_ev(8'd20);       push("R11", SIG_IRQ, 1);
        rd(8'h0E, "R11", 8'd7);
        rd(8'h0F, "R11", 8'd8);
        idle(); idle(); idle();
        wait (sbq.size() == 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule